// File: doc/BRIEF.md
# Key-Matrix and Wake-Up Interrupt Aggregator

This block gathers sixteen active-low key-input lines and eight wake-up lines and turns them into a small set of interrupt requests for a CPU interrupt controller. The key lines form two groups of eight: lines 7..0 make up the low group and lines 15..8 the high group. A falling edge on an unmasked key line raises a one-cycle request strobe on its group's single request output. Per-line key status is not kept. Only the group strobe is visible.

Two dedicated external interrupt requests share pins with the key logic. The low-IRQ request normally comes from key line 6. The high-IRQ request normally comes from a shared pin that the high key group's masks govern. A vector-mode bit changes this sharing. In extended mode, the low-IRQ request comes only from its own dedicated pin. A source-select bit then chooses the shared or the dedicated pin for the high-IRQ request, and the key masks stop affecting it. Each wake-up line has its own edge polarity and enable. A detected edge sets a sticky flag that software clears by writing a one.

All pins pass through a configurable synchronizer before edge detection. An 8-bit register port holds the masks, the wake-up edge selects and enables, the mode and source select, and the wake-up flags.

Top module: `keywake_irq_agg`

## Requirements
- R1: After reset, both key mask registers (address 0 for lines 7..0, address 1 for lines 15..8) read 0xFF. The wake edge register (address 2), the wake enable register (address 3), the control register (address 4) and the wake flags (address 5) read 0x00. All request outputs are low.
- R2: A falling edge on an unmasked key line produces exactly one high cycle on `key_grp_irq[0]` for lines 7..0 or on `key_grp_irq[1]` for lines 15..8. When several lines of a group fall together, the result is still one pulse. A rising edge produces no pulse.
- R3: A key mask bit at 1 (address 0 bit n is line n, address 1 bit n is line 8+n) blocks that line from its group request.
- R4: In normal mode (control bit 0 = 0), `irq6_req` is high while key line 6 is low, but only when mask bit 6 is 0.
- R5: In normal mode, `irq7_req` is high while `irq7_pin_n` is low, but only when mask bits 15..8 are all 1. If any of them is 0, the pin is ignored.
- R6: In extended mode (control bit 0 = 1), `irq6_req` follows only `irq6_ded_n` being low. Key line 6 and its mask have no effect on it.
- R7: In extended mode, control bit 1 selects the `irq7_req` source: 0 selects `irq7_pin_n`, 1 selects `irq7_ded_n` (active low). Mask bits 15..8 have no effect.
- R8: Wake line n sets flag n on a rising edge when edge bit n is 1, or on a falling edge when edge bit n is 0, but only while enable bit n is 1. The flag holds and appears on `wake_irq[n]`.
- R9: Writing address 5 clears each flag whose data bit is 1. Data bits at 0 leave their flags unchanged.
- R10: When a clear write and a new qualified edge reach the same flag in the same cycle, the flag ends up set.
- R11: Registers at addresses 0 to 4 read back the last value written. The control register keeps all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_pin_n | input | 16 | Key lines, active low; line 6 doubles as the shared low-IRQ pin |
| irq7_pin_n | input | 1 | Shared high-IRQ pin, active low |
| irq6_ded_n | input | 1 | Dedicated low-IRQ pin, active low |
| irq7_ded_n | input | 1 | Dedicated high-IRQ pin, active low |
| wake_pin | input | 8 | Wake-up lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| key_grp_irq | output | 2 | Group request strobes: bit 0 for lines 7..0, bit 1 for lines 15..8 |
| irq6_req | output | 1 | Low-IRQ request, level |
| irq7_req | output | 1 | High-IRQ request, level |
| wake_irq | output | 8 | Sticky wake-up request flags |

## Verification
The assertions assume that the register port changes only between clock edges, and that pins idle high for key and IRQ lines and low for wake lines when reset is released. Under that assumption the synchronizer history after reset holds no false edge. The bench drives every pin and register input on the falling clock edge and holds each pin pattern for several cycles, so each change crosses the synchronizer cleanly. The bench lines up the same-cycle clear-and-set case by counting edges through the two synchronizer stages and the edge register.

// File: rtl/kw_pkg.sv
package kw_pkg;
   localparam int DW = 8;
   localparam int AW = 3;

   typedef enum logic [AW-1:0] {
      A_MASK_LO = 3'd0,
      A_MASK_HI = 3'd1,
      A_WEDGE   = 3'd2,
      A_WEN     = 3'd3,
      A_CTRL    = 3'd4,
      A_WFLAG   = 3'd5
   } kw_addr_e;

   typedef struct packed {
      logic [DW-3:0] spare;
      logic          irq7_ded;   // bit 1
      logic          ext_mode;   // bit 0
   } kw_ctrl_t;
endpackage

// File: rtl/kw_sync.sv
module kw_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("kw_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st[s] <= {W{RST_VAL}};
         else if (s == 0) st[s] <= d;
         else             st[s] <= st[(s == 0) ? 0 : s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/kw_regs.sv
module kw_regs
   import kw_pkg::*;
#(
   parameter int KEY_W  = 16,
   parameter int WAKE_N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   input  logic [WAKE_N-1:0] wake_flags,
   output logic [KEY_W-1:0]  key_mask,
   output logic [WAKE_N-1:0] wake_edge,
   output logic [WAKE_N-1:0] wake_en,
   output kw_ctrl_t          ctrl,
   output logic [WAKE_N-1:0] wake_clr,
   output logic [DW-1:0]     rdata
);
   if (KEY_W != 2*DW) begin : g_bad_key
      $error("kw_regs: KEY_W must equal two register widths");
   end
   if (WAKE_N > DW || WAKE_N < 1) begin : g_bad_wake
      $error("kw_regs: WAKE_N must fit one register");
   end

   logic [DW-1:0] mask_lo_q, mask_hi_q, ctrl_q;
   logic [WAKE_N-1:0] edge_q, en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_lo_q <= '1;
         mask_hi_q <= '1;
         edge_q    <= '0;
         en_q      <= '0;
         ctrl_q    <= '0;
      end else if (we) begin
         unique case (addr)
            A_MASK_LO: mask_lo_q <= wdata;
            A_MASK_HI: mask_hi_q <= wdata;
            A_WEDGE:   edge_q    <= wdata[WAKE_N-1:0];
            A_WEN:     en_q      <= wdata[WAKE_N-1:0];
            A_CTRL:    ctrl_q    <= wdata;
            default: ;
         endcase
      end
   end

   assign key_mask  = {mask_hi_q, mask_lo_q};
   assign wake_edge = edge_q;
   assign wake_en   = en_q;
   assign ctrl      = kw_ctrl_t'(ctrl_q);
   assign wake_clr  = (we && addr == A_WFLAG) ? wdata[WAKE_N-1:0] : '0;

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_MASK_LO: rdata = mask_lo_q;
         A_MASK_HI: rdata = mask_hi_q;
         A_WEDGE:   rdata[WAKE_N-1:0] = edge_q;
         A_WEN:     rdata[WAKE_N-1:0] = en_q;
         A_CTRL:    rdata = ctrl_q;
         A_WFLAG:   rdata[WAKE_N-1:0] = wake_flags;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/kw_keygrp.sv
module kw_keygrp #(
   parameter int GROUPS = 2,
   parameter int GRP_W  = 8,
   localparam int KEY_W = GROUPS * GRP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KEY_W-1:0]  key_s,
   input  logic [KEY_W-1:0]  mask,
   output logic [GROUPS-1:0] grp_irq
);
   if (GROUPS < 1 || GRP_W < 1) begin : g_bad_shape
      $error("kw_keygrp: empty key group");
   end

   logic [KEY_W-1:0] prev_q;
   logic [KEY_W-1:0] fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= key_s;
   end

   assign fall = prev_q & ~key_s & ~mask;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) grp_irq[g] <= 1'b0;
         else        grp_irq[g] <= |fall[g*GRP_W +: GRP_W];
      end

      // R3
      grp_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
         grp_irq[g] |-> !(&$past(mask[g*GRP_W +: GRP_W])));
   end
endmodule

// File: rtl/kw_wake.sv
module kw_wake #(
   parameter int WAKE_N = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WAKE_N-1:0] wake_s,
   input  logic [WAKE_N-1:0] edge_rise,
   input  logic [WAKE_N-1:0] en,
   input  logic [WAKE_N-1:0] clr,
   output logic [WAKE_N-1:0] flags
);
   logic [WAKE_N-1:0] prev_q, set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= wake_s;
   end

   for (genvar i = 0; i < WAKE_N; i++) begin : g_line
      always_comb begin
         if (edge_rise[i]) set[i] = en[i] & ~prev_q[i] &  wake_s[i];
         else              set[i] = en[i] &  prev_q[i] & ~wake_s[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clr[i]) flags[i] <= 1'b0;
      end
   end

   // R8
   wake_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~$past(flags) & ~$past(en)) == '0);
   // R9
   wake_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (~flags & $past(flags) & ~$past(clr)) == '0);
   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set & clr) != '0) |=> ((flags & $past(set & clr)) == $past(set & clr)));
endmodule

// File: rtl/keywake_irq_agg.sv
module keywake_irq_agg
   import kw_pkg::*;
#(
   parameter int KEY_GROUPS  = 2,
   parameter int GRP_W       = 8,
   parameter int WAKE_N      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IRQ6_LINE   = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           key_pin_n,
   input  logic                  irq7_pin_n,
   input  logic                  irq6_ded_n,
   input  logic                  irq7_ded_n,
   input  logic [7:0]            wake_pin,
   input  logic                  reg_we,
   input  logic [2:0]            reg_addr,
   input  logic [7:0]            reg_wdata,
   output logic [7:0]            reg_rdata,
   output logic [1:0]            key_grp_irq,
   output logic                  irq6_req,
   output logic                  irq7_req,
   output logic [7:0]            wake_irq
);
   localparam int KEY_W = KEY_GROUPS * GRP_W;
   localparam int HI_LO = KEY_W - GRP_W;

   if (KEY_W != 16 || KEY_GROUPS != 2 || WAKE_N != 8) begin : g_bad_top
      $error("keywake_irq_agg: port widths fix two groups of eight keys and eight wake lines");
   end
   if (IRQ6_LINE < 0 || IRQ6_LINE >= GRP_W) begin : g_bad_line
      $error("keywake_irq_agg: IRQ6_LINE must lie in the low group");
   end

   logic [KEY_W+2:0]  pin_s;
   logic [KEY_W-1:0]  key_s, key_mask;
   logic              irq7_s, ded6_s, ded7_s;
   logic [WAKE_N-1:0] wake_s, wake_edge, wake_en, wake_clr, wake_flags;
   kw_ctrl_t          ctrl;
   logic              irq7_src_n, irq7_gate;

   kw_sync #(.W(KEY_W+3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_key (
      .clk, .rst_n,
      .d({irq7_ded_n, irq6_ded_n, irq7_pin_n, key_pin_n}),
      .q(pin_s));

   assign key_s  = pin_s[KEY_W-1:0];
   assign irq7_s = pin_s[KEY_W];
   assign ded6_s = pin_s[KEY_W+1];
   assign ded7_s = pin_s[KEY_W+2];

   kw_sync #(.W(WAKE_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wake (
      .clk, .rst_n, .d(wake_pin), .q(wake_s));

   kw_regs #(.KEY_W(KEY_W), .WAKE_N(WAKE_N)) u_regs (
      .clk, .rst_n,
      .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .wake_flags(wake_flags),
      .key_mask(key_mask), .wake_edge(wake_edge), .wake_en(wake_en),
      .ctrl(ctrl), .wake_clr(wake_clr), .rdata(reg_rdata));

   kw_keygrp #(.GROUPS(KEY_GROUPS), .GRP_W(GRP_W)) u_keys (
      .clk, .rst_n, .key_s(key_s), .mask(key_mask), .grp_irq(key_grp_irq));

   kw_wake #(.WAKE_N(WAKE_N)) u_wake (
      .clk, .rst_n, .wake_s(wake_s), .edge_rise(wake_edge), .en(wake_en),
      .clr(wake_clr), .flags(wake_flags));

   assign wake_irq = wake_flags;

   // Vector-mode routing of the two dedicated requests
   always_comb begin
      if (ctrl.ext_mode) begin
         irq6_req   = ~ded6_s;
         irq7_src_n = ctrl.irq7_ded ? ded7_s : irq7_s;
         irq7_gate  = 1'b1;
      end else begin
         irq6_req   = ~key_s[IRQ6_LINE] & ~key_mask[IRQ6_LINE];
         irq7_src_n = irq7_s;
         irq7_gate  = &key_mask[KEY_W-1:HI_LO];
      end
      irq7_req = irq7_gate & ~irq7_src_n;
   end

   // R4
   irq6_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.ext_mode && key_mask[IRQ6_LINE]) |-> !irq6_req);
   // R5
   irq7_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.ext_mode && !(&key_mask[KEY_W-1:HI_LO])) |-> !irq7_req);
   // R6
   irq6_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.ext_mode && ded6_s) |-> !irq6_req);
endmodule

// File: tb/tb_keywake_irq_agg.sv
`timescale 1ns/1ps
module tb_keywake_irq_agg;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic [15:0] key_pin_n = '1;
   logic        irq7_pin_n = 1'b1, irq6_ded_n = 1'b1, irq7_ded_n = 1'b1;
   logic [7:0]  wake_pin = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata, wake_irq;
   logic [1:0]  key_grp_irq;
   logic        irq6_req, irq7_req;

   int checks = 0, errors = 0;
   int pulses0 = 0, pulses1 = 0;
   bit done = 0;

   always #4 clk = ~clk;

   keywake_irq_agg dut (.*);

   always @(negedge clk) begin
      if (key_grp_irq[0]) pulses0++;
      if (key_grp_irq[1]) pulses1++;
   end

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   // {mask[15:0], falling lines[15:0], expected group pulses[1:0]}
   localparam logic [33:0] KVEC [7] = '{
      {16'h0000, 16'h0001, 2'b01},
      {16'h0000, 16'h4000, 2'b10},
      {16'h0000, 16'h8001, 2'b11},
      {16'hFFFF, 16'hFFFF, 2'b00},
      {16'hFF00, 16'h0F0F, 2'b01},
      {16'h0001, 16'h0001, 2'b00},
      {16'h7FFF, 16'h8000, 2'b10}
   };

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      int p0, p1;
      settle(3);
      rst_n = 1'b1;
      settle(2);

      // R1 reset state
      rd(3'd0, r); chk("R1 mask lo", r, 8'hFF);
      rd(3'd1, r); chk("R1 mask hi", r, 8'hFF);
      rd(3'd2, r); chk("R1 wake edge", r, 8'h00);
      rd(3'd3, r); chk("R1 wake en", r, 8'h00);
      rd(3'd4, r); chk("R1 ctrl", r, 8'h00);
      rd(3'd5, r); chk("R1 flags", r, 8'h00);
      chk("R1 outputs", {key_grp_irq, irq6_req, irq7_req, wake_irq}, 16'h0000);

      // R2 / R3 vector walk
      foreach (KVEC[i]) begin
         wr(3'd0, KVEC[i][25:18]);
         wr(3'd1, KVEC[i][33:26]);
         p0 = pulses0; p1 = pulses1;
         key_pin_n = ~KVEC[i][17:2];
         settle(6);
         chk($sformatf("R2 R3 vec%0d fall", i), {14'd0, 1'(pulses1 - p1), 1'(pulses0 - p0)},
             {14'd0, KVEC[i][1:0]});
         chk($sformatf("R2 vec%0d count", i), 16'(pulses0 - p0 + pulses1 - p1),
             16'(KVEC[i][1] + KVEC[i][0]));
         p0 = pulses0; p1 = pulses1;
         key_pin_n = '1;
         settle(6);
         chk($sformatf("R2 vec%0d rise", i), 16'(pulses0 - p0 + pulses1 - p1), 16'd0);
      end

      // R11 readback
      wr(3'd4, 8'hA4); rd(3'd4, r); chk("R11 ctrl readback", r, 8'hA4);
      wr(3'd2, 8'h5A); rd(3'd2, r); chk("R11 edge readback", r, 8'h5A);
      wr(3'd4, 8'h00);

      // R4 normal-mode low IRQ on key line 6
      wr(3'd0, 8'hBF);
      key_pin_n[6] = 1'b0; settle(4);
      chk("R4 unmasked", 16'(irq6_req), 16'd1);
      wr(3'd0, 8'hFF); settle(1);
      chk("R4 masked", 16'(irq6_req), 16'd0);
      key_pin_n[6] = 1'b1; settle(4);

      // R5 normal-mode high IRQ
      irq7_pin_n = 1'b0; settle(4);
      wr(3'd1, 8'hFF); settle(1);
      chk("R5 all masked", 16'(irq7_req), 16'd1);
      wr(3'd1, 8'hFE); settle(1);
      chk("R5 one unmasked", 16'(irq7_req), 16'd0);
      irq7_pin_n = 1'b1; settle(4);

      // R6 extended-mode low IRQ
      wr(3'd4, 8'h01);
      wr(3'd0, 8'h00);
      key_pin_n[6] = 1'b0; settle(4);
      chk("R6 shared pin ignored", 16'(irq6_req), 16'd0);
      irq6_ded_n = 1'b0; settle(4);
      chk("R6 dedicated pin", 16'(irq6_req), 16'd1);
      irq6_ded_n = 1'b1; key_pin_n[6] = 1'b1; settle(4);
      chk("R6 dedicated released", 16'(irq6_req), 16'd0);

      // R7 extended-mode high IRQ source select, masks 15..8 = 0x00
      wr(3'd1, 8'h00);
      irq7_pin_n = 1'b0; settle(4);
      chk("R7 shared pin, masks ignored", 16'(irq7_req), 16'd1);
      wr(3'd4, 8'h03); settle(1);
      chk("R7 dedicated selected idle", 16'(irq7_req), 16'd0);
      irq7_ded_n = 1'b0; settle(4);
      chk("R7 dedicated pin", 16'(irq7_req), 16'd1);
      irq7_ded_n = 1'b1; irq7_pin_n = 1'b1; settle(4);
      wr(3'd4, 8'h00); wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);

      // R8 wake edges: line0 rising, others falling; lines 0..2 enabled
      wr(3'd2, 8'h01);
      wr(3'd3, 8'h07);
      wake_pin[0] = 1'b1; settle(5);
      chk("R8 rising line0", 16'(wake_irq), 16'h01);
      wake_pin[1] = 1'b1; settle(5);
      chk("R8 rising ignored on falling line1", 16'(wake_irq), 16'h01);
      wake_pin[1] = 1'b0; settle(5);
      chk("R8 falling line1", 16'(wake_irq), 16'h03);
      wake_pin[4] = 1'b1; settle(5); wake_pin[4] = 1'b0; settle(5);
      rd(3'd5, r); chk("R8 disabled line4", r, 8'h03);

      // R9 write-one-to-clear
      wr(3'd5, 8'h00); rd(3'd5, r); chk("R9 zero write", r, 8'h03);
      wr(3'd5, 8'h01); rd(3'd5, r); chk("R9 clear line0", r, 8'h02);
      wr(3'd5, 8'h02); rd(3'd5, r); chk("R9 clear line1", r, 8'h00);

      // R10 clear and set in the same cycle on line 3 (rising)
      wr(3'd2, 8'h08);
      wr(3'd3, 8'h08);
      @(negedge clk); wake_pin[3] = 1'b1;
      @(negedge clk);
      @(negedge clk); reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h08;
      @(negedge clk); reg_we = 1'b0;
      settle(2);
      chk("R10 set wins", 16'(wake_irq), 16'h08);
      wr(3'd5, 8'h08); settle(1);
      chk("R9 R10 cleared after", 16'(wake_irq), 16'h00);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule